// File: doc/BRIEF.md
# ARINC 429 Word Transmitter with Eight-Word Queue

This block takes 31-bit ARINC 429 words from a 16-bit host bus, queues up to eight of them, and sends each one serially on a pair of return-to-zero lines. One line carries ones and the other carries zeroes. The host writes a word in two halves using two separate strobes. The block then appends a parity bit, which is odd or even depending on a control input. It sends the 32 bits least-numbered ARINC bit first and leaves a fixed gap of null bits between words.

The bit timing comes from a divider on the master clock. The divider runs at one tenth of the master clock for high speed and one eightieth for low speed, and it is also brought out as a transmit clock. A ready flag tells the host when nothing is waiting or in flight. While the transmit enable is held high, queued words go out back to back. If the enable is dropped mid-word, that word is discarded and the words still queued are kept.

Top module: `a429_tx_fifo`

## Requirements
- R1: A word is entered by a `load_lo` pulse followed by a `load_hi` pulse. A `load_hi` pulse with no `load_lo` since the previous `load_hi` is ignored. ARINC bit k (1..32) is mapped from the bus as follows. Bits 1..8 come from the `load_lo` bus bits 7 down to 0. Bits 9..13 come from `load_lo` bus bits 11..15. Bit 30 comes from `load_lo` bus bit 9 and bit 31 from `load_lo` bus bit 10. Bits 14..29 come from the `load_hi` bus bits 0..15.
- R2: The queue holds 8 words. A completed load while 8 words are queued is dropped.
- R3: `tx_ready` is 1 after reset. It goes 0 in the cycle after a word is accepted. It returns to 1 one cycle after the queue is empty and the transmitter is idle, with no word accepted in that cycle.
- R4: `tx_clk_out` has a period of 10 master clocks when `slow_rate` is 0 and 80 when it is 1. It is high for the first half of each period.
- R5: Each bit occupies one transmit clock period. Its line is active for the first half of the period and null for the second half.
- R6: After the 32nd bit, both lines stay null for 4 bit periods (40 or 320 clocks) before the next word can start.
- R7: With `tx_en` high and a word queued, transmission starts at the next transmit clock period boundary, so the first bit begins within one bit period. ARINC bit 1 is sent first.
- R8: Bit 32 makes the total count of ones odd when `par_even` is 0 and even when it is 1. The value of `par_even` is taken when the word leaves the queue.
- R9: A one drives `line_one` high and a zero drives `line_zero` high. The two are never high together, and both are low in null halves, gaps and idle.
- R10: Words leave in the order they were accepted. Transmission stops once every accepted word has been sent.
- R11: Dropping `tx_en` during a word or gap returns the transmitter to idle on the next clock, and that word is lost. Words still queued are sent once `tx_en` is high again.
- R12: Reset (`rst_n` low) empties the queue, sets `tx_ready`, drives both lines low and forgets a half-loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_lo | input | 1 | Strobe for the first half of a word |
| load_hi | input | 1 | Strobe for the second half; completes the word |
| bus_data | input | 16 | Host data bus |
| tx_en | input | 1 | Transmission enable |
| slow_rate | input | 1 | 0: divide by 10, 1: divide by 80 |
| par_even | input | 1 | 0: odd parity, 1: even parity |
| line_one | output | 1 | Return-to-zero ones line |
| line_zero | output | 1 | Return-to-zero zeroes line |
| tx_clk_out | output | 1 | Transmit bit clock |
| tx_ready | output | 1 | High when the queue is empty and the transmitter idle |

## Verification
The in-design properties assume that the two load strobes are single-cycle pulses that are never raised together. They also assume that `slow_rate` changes only while the block is held in reset, because the bit timing is derived from the live divisor. The stimulus respects both conditions. Each strobe is raised for exactly one clock, the two strobes are separated by a cycle, and the rate is switched only inside a reset pulse. The enable, by contrast, is toggled freely, including in the middle of a word, because aborting a word is a defined behaviour.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_SEND = 2'd1,
      TX_GAP  = 2'd2
   } tx_state_e;

   // Assemble the 31 data bits (index i holds ARINC bit i+1) from two bus halves.
   function automatic logic [30:0] pack_word(input logic [15:0] lo, input logic [15:0] hi);
      logic [30:0] w;
      for (int i = 0; i < 8; i++) w[i] = lo[7-i];
      for (int i = 0; i < 5; i++) w[8+i] = lo[11+i];
      for (int i = 0; i < 16; i++) w[13+i] = hi[i];
      w[29] = lo[9];
      w[30] = lo[10];
      return w;
   endfunction

endpackage

// File: rtl/a429_rate_div.sv
module a429_rate_div #(
   parameter int FAST_DIV = 10,
   parameter int SLOW_DIV = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow,
   output logic tick,
   output logic first_half
);
   localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
   localparam int CNT_W   = $clog2(MAX_DIV);

   if (FAST_DIV < 2 || (FAST_DIV % 2) != 0) begin : g_bad_fast
      $error("FAST_DIV must be even and at least 2");
   end
   if (SLOW_DIV < 2 || (SLOW_DIV % 2) != 0) begin : g_bad_slow
      $error("SLOW_DIV must be even and at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;
   logic [CNT_W-1:0] half_cnt;

   assign last_cnt   = slow ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
   assign half_cnt   = slow ? CNT_W'(SLOW_DIV / 2) : CNT_W'(FAST_DIV / 2);
   assign tick       = (cnt_q >= last_cnt);
   assign first_half = (cnt_q < half_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
   parameter int WORD_W = 31,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_data,
   input  logic              pop,
   output logic [WORD_W-1:0] head,
   output logic              empty,
   output logic              full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, wr_ptr_inc, rd_ptr_inc;
   logic [CNT_W-1:0]  cnt_q;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign wr_ptr_inc = wr_ptr_q + 1'b1;
      assign rd_ptr_inc = rd_ptr_q + 1'b1;
   end else begin : g_cmp_wrap
      assign wr_ptr_inc = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_ptr_inc = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
   end

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign head  = mem[rd_ptr_q];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_inc;
         if (pop)  rd_ptr_q <= rd_ptr_inc;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full) else $error("push into full queue"); // R2
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty) else $error("pop from empty queue"); // R10

endmodule

// File: rtl/a429_loader.sv
module a429_loader
   import a429_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_lo,
   input  logic        load_hi,
   input  logic [15:0] bus_data,
   input  logic        full,
   output logic        push,
   output logic [30:0] push_word
);
   logic        armed_q;
   logic [15:0] lo_q;

   assign push      = load_hi && armed_q && !full;
   assign push_word = pack_word(lo_q, bus_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         lo_q    <= '0;
      end else begin
         if (load_hi) armed_q <= 1'b0;
         if (load_lo) begin
            armed_q <= 1'b1;
            lo_q    <= bus_data;
         end
      end
   end

endmodule

// File: rtl/a429_serializer.sv
module a429_serializer
   import a429_tx_pkg::*;
#(
   parameter int WORD_W   = 31,
   parameter int GAP_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              par_even,
   input  logic              tick,
   input  logic              first_half,
   input  logic              empty,
   input  logic [WORD_W-1:0] head,
   output logic              pop,
   output logic              line_one,
   output logic              line_zero,
   output logic              idle
);
   localparam int FRAME_W = WORD_W + 1;
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam int GAP_W   = (GAP_BITS > 1) ? $clog2(GAP_BITS) : 1;

   if (GAP_BITS < 1) begin : g_bad_gap
      $error("GAP_BITS must be at least 1");
   end

   tx_state_e          st_q;
   logic [IDX_W-1:0]   idx_q;
   logic [GAP_W-1:0]   gap_q;
   logic [FRAME_W-1:0] sh_q;
   logic               last_bit, gap_done, start, parity, sending;

   assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));
   assign gap_done = (gap_q == GAP_W'(GAP_BITS - 1));
   assign start    = tx_en && tick && !empty &&
                     ((st_q == TX_IDLE) || ((st_q == TX_GAP) && gap_done));
   assign pop      = start;
   assign parity   = (^head) ^ ~par_even;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TX_IDLE;
         idx_q <= '0;
         gap_q <= '0;
         sh_q  <= '0;
      end else if (start) begin
         st_q  <= TX_SEND;
         idx_q <= '0;
         sh_q  <= {parity, head};
      end else begin
         case (st_q)
            TX_SEND: begin
               if (!tx_en) st_q <= TX_IDLE;
               else if (tick) begin
                  if (last_bit) begin
                     st_q  <= TX_GAP;
                     gap_q <= '0;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     sh_q  <= sh_q >> 1;
                  end
               end
            end
            TX_GAP: begin
               if (!tx_en) st_q <= TX_IDLE;
               else if (tick) begin
                  if (gap_done) st_q <= TX_IDLE;
                  else          gap_q <= gap_q + 1'b1;
               end
            end
            default: st_q <= st_q;
         endcase
      end
   end

   assign sending   = (st_q == TX_SEND) && first_half;
   assign line_one  = sending && sh_q[0];
   assign line_zero = sending && !sh_q[0];
   assign idle      = (st_q == TX_IDLE);

   AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_one && line_zero)) else $error("both lines active"); // R9
   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_en) |=> (!line_one && !line_zero && idle)) else $error("abort not honoured"); // R11

endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
   parameter int DEPTH    = 8,
   parameter int FAST_DIV = 10,
   parameter int SLOW_DIV = 80,
   parameter int GAP_BITS = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_lo,
   input  logic        load_hi,
   input  logic [15:0] bus_data,
   input  logic        tx_en,
   input  logic        slow_rate,
   input  logic        par_even,
   output logic        line_one,
   output logic        line_zero,
   output logic        tx_clk_out,
   output logic        tx_ready
);
   localparam int WORD_W = 31;

   logic              tick, first_half, push, pop, empty, full, idle;
   logic [WORD_W-1:0] push_word, head;
   logic              ready_q;

   a429_rate_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .slow(slow_rate),
      .tick(tick), .first_half(first_half)
   );

   a429_loader u_load (
      .clk(clk), .rst_n(rst_n), .load_lo(load_lo), .load_hi(load_hi),
      .bus_data(bus_data), .full(full), .push(push), .push_word(push_word)
   );

   a429_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_word),
      .pop(pop), .head(head), .empty(empty), .full(full)
   );

   a429_serializer #(.WORD_W(WORD_W), .GAP_BITS(GAP_BITS)) u_ser (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .par_even(par_even),
      .tick(tick), .first_half(first_half), .empty(empty), .head(head),
      .pop(pop), .line_one(line_one), .line_zero(line_zero), .idle(idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ready_q <= 1'b1;
      else if (push)           ready_q <= 1'b0;
      else if (empty && idle)  ready_q <= 1'b1;
   end

   assign tx_ready   = ready_q;
   assign tx_clk_out = first_half;

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !tx_ready) else $error("ready stayed high after load"); // R3
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (line_one || line_zero) |-> !tx_ready) else $error("ready while sending"); // R3

endmodule

// File: tb/a429_tx_fifo_test.sv
`timescale 1ns/1ps
module a429_tx_fifo_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_lo = 1'b0, load_hi = 1'b0;
   logic [15:0] bus_data = '0;
   logic        tx_en = 1'b0, slow_rate = 1'b0, par_even = 1'b0;
   logic        line_one, line_zero, tx_clk_out, tx_ready;

   a429_tx_fifo uut (
      .clk(clk), .rst_n(rst_n), .load_lo(load_lo), .load_hi(load_hi),
      .bus_data(bus_data), .tx_en(tx_en), .slow_rate(slow_rate),
      .par_even(par_even), .line_one(line_one), .line_zero(line_zero),
      .tx_clk_out(tx_clk_out), .tx_ready(tx_ready)
   );

   always #5 clk = ~clk;

   integer checks = 0, fails = 0, cyc = 0;
   string  scen = "R12 reset";
   logic   cmp_on = 1'b0;

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, scen, what, act, exp);
      end
   endtask

   // bench-side mapping: result bit k-1 holds ARINC bit k
   function automatic logic [30:0] ref_pack(input logic [15:0] lo, input logic [15:0] hi);
      logic [30:0] r;
      for (int k = 1; k <= 31; k++) begin
         if (k <= 8)       r[k-1] = lo[8-k];
         else if (k <= 13) r[k-1] = lo[k+2];
         else if (k <= 29) r[k-1] = hi[k-14];
         else              r[k-1] = lo[k-21];
      end
      return r;
   endfunction

   // reference model
   integer      m_cnt, m_st, m_bit, m_gap, lim, ones;
   logic        m_ready, m_armed, tk, emp, fl, wr, go;
   logic [15:0] m_lo;
   logic [31:0] m_bits;
   logic [30:0] mq[$];
   logic [30:0] w, wr_word;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_st = 0; m_bit = 0; m_gap = 0;
         m_ready = 1'b1; m_armed = 1'b0; m_lo = '0; m_bits = '0;
         mq.delete();
      end else begin
         lim     = slow_rate ? 80 : 10;
         tk      = (m_cnt >= lim - 1);
         emp     = (mq.size() == 0);
         fl      = (mq.size() >= 8);
         wr      = load_hi && m_armed && !fl;
         wr_word = ref_pack(m_lo, bus_data);
         go      = tx_en && tk && !emp && (m_st == 0 || (m_st == 2 && m_gap == 3));
         if (wr) m_ready = 1'b0;
         else if (emp && m_st == 0) m_ready = 1'b1;
         if (go) begin
            w = mq.pop_front();
            ones = 0;
            for (int i = 0; i < 31; i++) ones += w[i];
            m_bits = {(par_even ? ones[0] : ~ones[0]), w};
            m_bit = 0; m_st = 1;
         end else if (m_st == 1) begin
            if (!tx_en) m_st = 0;
            else if (tk) begin
               if (m_bit == 31) begin m_st = 2; m_gap = 0; end
               else m_bit++;
            end
         end else if (m_st == 2) begin
            if (!tx_en) m_st = 0;
            else if (tk) begin
               if (m_gap == 3) m_st = 0;
               else m_gap++;
            end
         end
         if (wr) mq.push_back(wr_word);
         if (load_hi) m_armed = 1'b0;
         if (load_lo) begin m_armed = 1'b1; m_lo = bus_data; end
         m_cnt = tk ? 0 : m_cnt + 1;
      end
   end

   always @(negedge clk) begin
      #1;
      if (cmp_on && rst_n) begin
         logic act_on, e_one, e_zero, e_clk;
         integer l2;
         l2     = slow_rate ? 80 : 10;
         e_clk  = (m_cnt < l2 / 2);
         act_on = (m_st == 1) && e_clk;
         e_one  = act_on && m_bits[m_bit];
         e_zero = act_on && !m_bits[m_bit];
         chk(tx_clk_out === e_clk, "R4", "tx_clk_out", 32'(tx_clk_out), 32'(e_clk));
         chk(line_one === e_one, "R5 R9", "line_one", 32'(line_one), 32'(e_one));
         chk(line_zero === e_zero, "R5 R9", "line_zero", 32'(line_zero), 32'(e_zero));
         chk(tx_ready === m_ready, "R3", "tx_ready", 32'(tx_ready), 32'(m_ready));
      end
   end

   task automatic load_word(input logic [15:0] lo, input logic [15:0] hi);
      @(negedge clk); bus_data = lo; load_lo = 1'b1;
      @(negedge clk); load_lo = 1'b0;
      @(negedge clk); bus_data = hi; load_hi = 1'b1;
      @(negedge clk); load_hi = 1'b0;
   endtask

   task automatic wait_idle(input integer limit);
      integer n = 0;
      while (!(tx_ready === 1'b1 && m_st == 0) && n < limit) begin
         @(negedge clk); n++;
      end
      chk(n < limit, "R10", "drain finished", 32'(n), 32'(limit));
      repeat (5) @(negedge clk);
   endtask

   task automatic check_reset_outputs;
      #2;
      chk(tx_ready === 1'b1, "R12", "ready in reset", 32'(tx_ready), 32'd1);
      chk(line_one === 1'b0, "R12", "line_one in reset", 32'(line_one), 32'd0);
      chk(line_zero === 1'b0, "R12", "line_zero in reset", 32'(line_zero), 32'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         fails++;
         $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check_reset_outputs();
      rst_n = 1'b1;
      cmp_on = 1'b1;
      repeat (3) @(negedge clk);

      scen = "R1 R7 single word odd parity";
      load_word(16'h5A3C, 16'hC3A5);
      tx_en = 1'b1;
      wait_idle(2000);

      scen = "R8 even parity three words";
      par_even = 1'b1;
      load_word(16'hFFFF, 16'h0000);
      load_word(16'h0001, 16'h8001);
      load_word(16'h7E00, 16'hFFFF);
      wait_idle(4000);
      par_even = 1'b0;

      scen = "R1 orphan second strobe";
      @(negedge clk); bus_data = 16'h1234; load_hi = 1'b1;
      @(negedge clk); load_hi = 1'b0;
      repeat (30) @(negedge clk);
      chk(tx_ready === 1'b1, "R1", "ready after orphan strobe", 32'(tx_ready), 32'd1);

      scen = "R2 R10 full queue";
      tx_en = 1'b0;
      for (int i = 0; i < 9; i++) load_word(16'(i * 16'h1111), 16'(16'hA000 + i));
      repeat (3) @(negedge clk);
      chk(tx_ready === 1'b0, "R2", "ready while queued", 32'(tx_ready), 32'd0);
      tx_en = 1'b1;
      wait_idle(6000);

      scen = "R11 abort mid word";
      load_word(16'h0F0F, 16'h1111);
      load_word(16'hF0F0, 16'h2222);
      repeat (150) @(negedge clk);
      tx_en = 1'b0;
      repeat (30) @(negedge clk);
      tx_en = 1'b1;
      wait_idle(2000);

      scen = "R12 reset mid word";
      load_word(16'hAAAA, 16'h5555);
      load_word(16'h3333, 16'hCCCC);
      repeat (100) @(negedge clk);
      @(negedge clk); bus_data = 16'h7777; load_lo = 1'b1;
      @(negedge clk); load_lo = 1'b0;
      cmp_on = 1'b0;
      rst_n = 1'b0;
      check_reset_outputs();
      slow_rate = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk); bus_data = 16'h9999; load_hi = 1'b1;
      @(negedge clk); load_hi = 1'b0;
      repeat (20) @(negedge clk);
      chk(tx_ready === 1'b1, "R12", "half word forgotten", 32'(tx_ready), 32'd1);

      scen = "R4 R6 slow rate two words";
      load_word(16'h1357, 16'h2468);
      load_word(16'hECA8, 16'hDB97);
      wait_idle(8000);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule